// File: doc/BRIEF.md
# Parity-Checked Direct-Mapped Instruction Cache

This block serves instruction fetches from a CPU. A fetch carries a 32-bit physical byte address, and the cache answers with a 32-bit word and a flag that says whether the word came from a hit. The arrays are indexed and tagged with physical addresses, so a context switch needs no flush, and every address in the 4 GB space can be cached. The cache is direct mapped. Each line holds four words (16 bytes).

Every stored word carries four even-parity bits, one per byte. Every tag carries one even-parity bit over the whole tag. The cache computes these bits itself as refill data is written, and checks them on every lookup. A mismatch in either the word or the tag makes the lookup behave exactly as a miss, so the line is fetched again. The requester sees no error, only a longer stall.

A configuration input selects the capacity at run time: full size, or half size. In half size the index loses its top bit and the tag gains that bit. Any change of this input clears every valid bit.

The controller is a three-state machine:
- `ST_LOOKUP`: compare the tag and both parity checks.
- `ST_FILL`: collect four refill words, lowest word first.
- `ST_REPLY`: return the requested word.

The transitions are:
- lookup-miss: `ST_LOOKUP` to `ST_FILL`, when a request misses.
- fill-last: `ST_FILL` to `ST_REPLY`, when the fourth word is accepted.
- fill-abort: `ST_FILL` to `ST_LOOKUP`, when the size setting changes.
- reply-done: `ST_REPLY` to `ST_LOOKUP`, unconditionally.
- A hit stays in `ST_LOOKUP`.

Top module: `pdic_icache`

## Requirements
- R1: After reset no line is valid. With no request, `fetch_valid_o`, `fetch_stall_o` and `refill_req_o` are all 0, and the first fetch of any address misses.
- R2: When a fetch finds its line valid, its tag equal and both parity checks clean, the cache answers in the same cycle the request is presented. It drives `fetch_valid_o`=1 and `fetch_hit_o`=1 with the stored word, and keeps `fetch_stall_o` and `refill_req_o` at 0.
- R3: On a miss, `fetch_stall_o` is 1 in the cycle the request is presented. It stays 1 until the cycle the word is returned, and it is 0 in that cycle.
- R4: A refill asks for the four words of the requested line in ascending order from word 0. The refill address is the fetch address with bits [3:2] set to the word number and bits [1:0] zero. A word is taken in any cycle in which both `refill_req_o` and `refill_valid_i` are 1, so refill data may arrive with gaps.
- R5: In the cycle after the fourth word is taken, the cache returns the requested word with `fetch_valid_o`=1 and `fetch_hit_o`=0. The line is then valid, and it hits on later fetches.
- R6: Parity is generated inside the cache as each refill word and its tag are written, so a freshly refilled line passes both checks.
- R7: A parity mismatch in a stored word turns the lookup of that word into a miss and a full line refill.
- R8: A parity mismatch in a stored tag turns the lookup of that line into a miss and a full line refill.
- R9: With `half_size_i`=0 the line index is address bits [8:4] and the tag is bits [31:9]. With `half_size_i`=1 the index is bits [7:4] and the tag is bits [31:8]. As a result, 0x000 and 0x100 occupy different lines at full size and the same line at half size.
- R10: Any change of `half_size_i` invalidates every line.
- R11: Two addresses with the same index and different tags evict each other.
- R12: Addresses at the top of the 4 GB space, such as 0xFFFF_FFF0, are cached and hit like any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_size_i | input | 1 | 1 selects half capacity; any change clears all lines |
| fetch_req_i | input | 1 | Fetch request; held with its address until `fetch_valid_o` |
| fetch_addr_i | input | 32 | Physical byte address of the fetch |
| fetch_valid_o | output | 1 | Word on `fetch_data_o` answers the current fetch |
| fetch_hit_o | output | 1 | Answer came from a lookup hit |
| fetch_stall_o | output | 1 | Fetch is waiting on a refill |
| fetch_data_o | output | 32 | Instruction word |
| refill_req_o | output | 1 | Refill word wanted at `refill_addr_o` |
| refill_addr_o | output | 32 | Address of the refill word wanted |
| refill_valid_i | input | 1 | `refill_data_i` carries the wanted word |
| refill_data_i | input | 32 | Refill word |

## Verification
The hardest case to reach from the ports is a parity mismatch. The cache generates its own parity, so no sequence of fetches and refills can ever store a bad bit. To reach the R7 and R8 paths, the stimulus first makes a line valid and confirms that it hits. On an idle cycle it then inverts one stored data bit, or the stored tag parity bit, inside the arrays. After that, the bench expects the next fetch of that line to miss, refill all four words, and return correct data, with a clean hit on the fetch that follows.

// File: rtl/pdic_pkg.sv
package pdic_pkg;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_FILL   = 2'd1,
        ST_REPLY  = 2'd2
    } ic_state_e;

    // even parity per byte: each bit makes its byte plus itself have an even count of ones
    function automatic logic [3:0] byte_par(input logic [31:0] w);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) begin
            p[b] = ^w[8*b +: 8];
        end
        return p;
    endfunction

endpackage

// File: rtl/pdic_data_store.sv
module pdic_data_store
    import pdic_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [IDX_W+1:0]     waddr_i,
    input  logic [31:0]          wdata_i,
    input  logic [IDX_W+1:0]     raddr_i,
    output logic [31:0]          rdata_o,
    output logic                 par_ok_o
);
    localparam int DEPTH = 1 << (IDX_W + 2);

    logic [35:0] mem_q [DEPTH];
    logic [35:0] rword;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= {byte_par(wdata_i), wdata_i};
        end
    end

    assign rword    = mem_q[raddr_i];
    assign rdata_o  = rword[31:0];
    assign par_ok_o = (byte_par(rword[31:0]) == rword[35:32]);

    // R6: a word just written carries parity consistent with its data
    assert_parity_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (byte_par(mem_q[$past(waddr_i)][31:0]) == mem_q[$past(waddr_i)][35:32]));

endmodule

// File: rtl/pdic_tag_store.sv
module pdic_tag_store #(
    parameter int IDX_W = 5,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [TAG_W-1:0] wtag_i,
    output logic             rvalid_o,
    output logic [TAG_W-1:0] rtag_o,
    output logic             rtag_ok_o
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic             tpar_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            valid_q <= '0;
        end else if (we_i) begin
            valid_q[idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i && !clr_i) begin
            tag_q[idx_i]  <= wtag_i;
            tpar_q[idx_i] <= ^wtag_i;
        end
    end

    assign rvalid_o  = valid_q[idx_i];
    assign rtag_o    = tag_q[idx_i];
    assign rtag_ok_o = ((^rtag_o) == tpar_q[idx_i]);

    // R10: a clear leaves no valid line behind
    assert_clear_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> ($countones(valid_q) == 0));

endmodule

// File: rtl/pdic_ctrl.sv
module pdic_ctrl
    import pdic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       hit_ok_i,
    input  logic       cfg_chg_i,
    input  logic       refill_valid_i,
    output logic       valid_o,
    output logic       hit_o,
    output logic       stall_o,
    output logic       refill_req_o,
    output logic [1:0] word_o,
    output logic       data_we_o,
    output logic       tag_we_o
);
    ic_state_e  state_q, state_d;
    logic [1:0] cnt_q, cnt_d;
    logic       take;

    assign take = refill_valid_i && !cfg_chg_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
            cnt_q   <= 2'd0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_LOOKUP: begin
                cnt_d = 2'd0;
                if (req_i && !hit_ok_i && !cfg_chg_i) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (cfg_chg_i) begin
                    state_d = ST_LOOKUP;
                end else if (take) begin
                    cnt_d = cnt_q + 2'd1;
                    if (cnt_q == 2'd3) state_d = ST_REPLY;
                end
            end
            ST_REPLY: state_d = ST_LOOKUP;
            default:  state_d = ST_LOOKUP;
        endcase
    end

    always_comb begin
        valid_o      = 1'b0;
        hit_o        = 1'b0;
        stall_o      = 1'b0;
        refill_req_o = 1'b0;
        data_we_o    = 1'b0;
        tag_we_o     = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                valid_o = req_i && hit_ok_i && !cfg_chg_i;
                hit_o   = req_i && hit_ok_i && !cfg_chg_i;
                stall_o = req_i && !(hit_ok_i && !cfg_chg_i);
            end
            ST_FILL: begin
                stall_o      = 1'b1;
                refill_req_o = 1'b1;
                data_we_o    = take;
                tag_we_o     = take && (cnt_q == 2'd3);
            end
            ST_REPLY: valid_o = 1'b1;
            default: ;
        endcase
    end

    assign word_o = cnt_q;

    // R4: each taken word before the last advances the word number by one
    assert_word_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && take && cnt_q != 2'd3) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R3: a miss starts a fill at word 0
    assert_fill_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && req_i && !hit_ok_i && !cfg_chg_i) |=> (state_q == ST_FILL && cnt_q == 2'd0));

endmodule

// File: rtl/pdic_icache.sv
module pdic_icache
    import pdic_pkg::*;
#(
    parameter int FULL_IDX_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        half_size_i,
    input  logic        fetch_req_i,
    input  logic [31:0] fetch_addr_i,
    output logic        fetch_valid_o,
    output logic        fetch_hit_o,
    output logic        fetch_stall_o,
    output logic [31:0] fetch_data_o,
    output logic        refill_req_o,
    output logic [31:0] refill_addr_o,
    input  logic        refill_valid_i,
    input  logic [31:0] refill_data_i
);
    localparam int TAG_LSB = FULL_IDX_W + 3;
    localparam int TAG_W   = 32 - TAG_LSB;

    logic                  half_q, cfg_chg;
    logic [FULL_IDX_W-1:0] idx;
    logic [TAG_W-1:0]      tag, rtag;
    logic                  rvalid, rtag_ok, dpar_ok, hit_ok;
    logic [1:0]            word;
    logic                  data_we, tag_we;
    logic                  unused_byte_bits;

    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= half_size_i;
    end

    assign cfg_chg = (half_size_i != half_q);
    assign idx     = half_q ? {1'b0, fetch_addr_i[FULL_IDX_W+2:4]}
                            : fetch_addr_i[FULL_IDX_W+3:4];
    assign tag     = fetch_addr_i[31:TAG_LSB];
    assign unused_byte_bits = ^fetch_addr_i[1:0];

    pdic_tag_store #(.IDX_W(FULL_IDX_W), .TAG_W(TAG_W)) u_tag (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (cfg_chg),
        .we_i      (tag_we),
        .idx_i     (idx),
        .wtag_i    (tag),
        .rvalid_o  (rvalid),
        .rtag_o    (rtag),
        .rtag_ok_o (rtag_ok)
    );

    pdic_data_store #(.IDX_W(FULL_IDX_W)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (data_we),
        .waddr_i  ({idx, word}),
        .wdata_i  (refill_data_i),
        .raddr_i  ({idx, fetch_addr_i[3:2]}),
        .rdata_o  (fetch_data_o),
        .par_ok_o (dpar_ok)
    );

    assign hit_ok = rvalid && (rtag == tag) && rtag_ok && dpar_ok;

    pdic_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (fetch_req_i),
        .hit_ok_i       (hit_ok),
        .cfg_chg_i      (cfg_chg),
        .refill_valid_i (refill_valid_i),
        .valid_o        (fetch_valid_o),
        .hit_o          (fetch_hit_o),
        .stall_o        (fetch_stall_o),
        .refill_req_o   (refill_req_o),
        .word_o         (word),
        .data_we_o      (data_we),
        .tag_we_o       (tag_we)
    );

    assign refill_addr_o = {fetch_addr_i[31:4], word, 2'b00};

    // R2: a hit neither stalls nor refills
    assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_hit_o |-> (!refill_req_o && !fetch_stall_o));

    // R5: the end of a refill hands back the word as a non-hit answer
    assert_reply_after_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(refill_req_o) && !$past(cfg_chg)) |-> (fetch_valid_o && !fetch_hit_o));

    // R3: a stall ends only when the word is returned
    assert_stall_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(fetch_stall_o) && fetch_req_i) |-> fetch_valid_o);

endmodule

// File: tb/pdic_icache_tb.sv
module pdic_icache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_size_i = 1'b0;
    logic        fetch_req_i = 1'b0;
    logic [31:0] fetch_addr_i = '0;
    logic        fetch_valid_o, fetch_hit_o, fetch_stall_o;
    logic [31:0] fetch_data_o;
    logic        refill_req_o;
    logic [31:0] refill_addr_o;
    logic        refill_valid_i = 1'b0;
    logic [31:0] refill_data_i = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] exp_addr_q[$];
    logic        exp_hit_q[$];
    string       exp_req_q[$];

    int k_word = 0;
    int gap_cnt = 0;

    always #4 clk = ~clk;

    pdic_icache dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .half_size_i    (half_size_i),
        .fetch_req_i    (fetch_req_i),
        .fetch_addr_i   (fetch_addr_i),
        .fetch_valid_o  (fetch_valid_o),
        .fetch_hit_o    (fetch_hit_o),
        .fetch_stall_o  (fetch_stall_o),
        .fetch_data_o   (fetch_data_o),
        .refill_req_o   (refill_req_o),
        .refill_addr_o  (refill_addr_o),
        .refill_valid_i (refill_valid_i),
        .refill_data_i  (refill_data_i)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops the expected answer whenever the cache returns a word
    always @(negedge clk) begin
        if (rst_n && fetch_valid_o && !done) begin
            if (exp_addr_q.size() == 0) begin
                check("R2 unexpected answer", 32'd1, 32'd0);
            end else begin
                logic [31:0] a;
                logic        h;
                string       r;
                a = exp_addr_q.pop_front();
                h = exp_hit_q.pop_front();
                r = exp_req_q.pop_front();
                check(r, fetch_data_o, mem_word({a[31:2], 2'b00}));
                check(r, {31'd0, fetch_hit_o}, {31'd0, h});
            end
        end
    end

    // refill responder, with gaps, checking word order (R4)
    always @(negedge clk) begin
        if (rst_n && refill_req_o && !done) begin
            check("R4 refill address", refill_addr_o,
                  {fetch_addr_i[31:4], k_word[1:0], 2'b00});
            gap_cnt++;
            #1;
            if ((gap_cnt % 3) != 0) begin
                refill_valid_i = 1'b1;
                refill_data_i  = mem_word(refill_addr_o);
                k_word = (k_word + 1) % 4;
            end else begin
                refill_valid_i = 1'b0;
            end
        end else begin
            #1;
            refill_valid_i = 1'b0;
        end
    end

    // driver: pushes the expected answer and holds the request until answered
    task automatic do_fetch(input logic [31:0] a, input logic exp_hit, input string req);
        int cyc;
        exp_addr_q.push_back(a);
        exp_hit_q.push_back(exp_hit);
        exp_req_q.push_back(req);
        @(negedge clk);
        #1;
        fetch_req_i  = 1'b1;
        fetch_addr_i = a;
        cyc = 0;
        forever begin
            @(negedge clk);
            if (cyc == 0) begin
                if (exp_hit) check({req, " R2 same-cycle answer"}, {31'd0, fetch_valid_o}, 32'd1);
                else         check({req, " R3 stall on miss"}, {31'd0, fetch_stall_o}, 32'd1);
            end
            if (fetch_valid_o) begin
                check({req, " R3 stall low on answer"}, {31'd0, fetch_stall_o}, 32'd0);
                break;
            end
            cyc++;
            if (cyc > 100) break;
        end
        #1;
        fetch_req_i = 1'b0;
    endtask

    task automatic set_half(input logic v);
        @(negedge clk);
        #1;
        half_size_i = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid idle", {31'd0, fetch_valid_o}, 32'd0);
        check("R1 stall idle", {31'd0, fetch_stall_o}, 32'd0);
        check("R1 refill idle", {31'd0, refill_req_o}, 32'd0);

        do_fetch(32'h0000_0040, 1'b0, "R1 first fetch misses R5");
        do_fetch(32'h0000_0044, 1'b1, "R6 hit word1");
        do_fetch(32'h0000_0048, 1'b1, "R6 hit word2");
        do_fetch(32'h0000_004C, 1'b1, "R6 hit word3");
        do_fetch(32'h0000_0040, 1'b1, "R2 hit word0");
        do_fetch(32'h1234_5678, 1'b0, "R5 miss mid-line word");
        do_fetch(32'h1234_5670, 1'b1, "R2 hit other word");

        do_fetch(32'h0000_0240, 1'b0, "R11 conflict fill");
        do_fetch(32'h0000_0040, 1'b0, "R11 evicted");
        do_fetch(32'h0000_0240, 1'b0, "R11 evicted back");
        do_fetch(32'h0000_0040, 1'b0, "R11 refill again");

        do_fetch(32'hFFFF_FFF0, 1'b0, "R12 top miss");
        do_fetch(32'hFFFF_FFFC, 1'b1, "R12 top hit");

        // R7: corrupt data bit of line 4 word 0 on an idle cycle
        @(negedge clk);
        dut_i.u_data.mem_q[16][0] <= ~dut_i.u_data.mem_q[16][0];
        do_fetch(32'h0000_0040, 1'b0, "R7 data parity miss");
        do_fetch(32'h0000_0040, 1'b1, "R7 hit after repair");

        // R8: corrupt tag parity of line 7
        @(negedge clk);
        dut_i.u_tag.tpar_q[7] <= ~dut_i.u_tag.tpar_q[7];
        do_fetch(32'h1234_5674, 1'b0, "R8 tag parity miss");
        do_fetch(32'h1234_5670, 1'b1, "R8 hit after repair");

        do_fetch(32'h0000_0000, 1'b0, "R9 full line0");
        do_fetch(32'h0000_0100, 1'b0, "R9 full line16");
        do_fetch(32'h0000_0004, 1'b1, "R9 full line0 kept");
        do_fetch(32'h0000_0104, 1'b1, "R9 full line16 kept");

        set_half(1'b1);
        do_fetch(32'h0000_0040, 1'b0, "R10 cleared on half");
        do_fetch(32'h0000_0000, 1'b0, "R9 half line0");
        do_fetch(32'h0000_0100, 1'b0, "R9 half same line");
        do_fetch(32'h0000_0000, 1'b0, "R9 half evicted");
        do_fetch(32'h0000_0044, 1'b1, "R9 half line4 kept");

        set_half(1'b0);
        do_fetch(32'h0000_0044, 1'b0, "R10 cleared on full");

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", exp_addr_q.size(), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule